// File: doc/BRIEF.md
# Testable swap-gate master-slave D flip-flop

This block is a rising-edge D flip-flop assembled from two level-sensitive latches placed one after the other. Every latch is built from controlled-swap gates. A controlled-swap gate with inputs (a, b, c) passes a through unchanged. It routes b and c straight through when a is 0 and exchanges them when a is 1. Its three outputs therefore carry as many ones as its three inputs. Any signal that feeds two loads is first duplicated by a swap gate wired as a copy element. The clock is split into two opposite-phase enables by a swap gate wired as an inverter.

Each latch holds its value through a feedback tap. That tap is made by a swap gate whose select is the stored bit and whose two data inputs are the latch's pair of mode controls. With the pair at (0,1), the tap repeats the stored bit, so the flip-flop stores data normally. With both controls of the pair at the same value, the tap becomes that constant and the loop is open. The flip-flop can then be tested as plain combinational logic with an all-zeros vector, which finds stuck-at-1 faults, or with an all-ones vector, which finds stuck-at-0 faults. Both feedback taps are brought out as ports so a tester can observe them.

An asynchronous active-low reset clears both latch stores. The reset is meant to be released synchronously, while the clock is low.

Top module: `swapgate_msdff`

## Requirements
- R1: When the controls {mst_c1, mst_c2, slv_c1, slv_c2} equal 4'b0101 (normal mode), q takes the value of d present at a rising clock edge and shows it during the high phase that follows.
- R2: In normal mode, q keeps its value between rising edges. A change of d during the low phase or the high phase has no effect on q until the next rising edge.
- R3: In normal mode, mst_tap equals d while clk is low (the master latch is transparent) and equals q while clk is high. slv_tap equals q at all times.
- R4: When the controls equal 4'b0000 (all-zeros test mode), mst_tap and slv_tap are both 0 in both clock phases, whatever d is.
- R5: In all-zeros test mode, q is 0 in both clock phases, whatever d is.
- R6: When the controls equal 4'b1111 (all-ones test mode), mst_tap, slv_tap and q are all 1 in both clock phases, whatever d is.
- R7: While rst_n is 0 in normal mode, q, mst_tap and slv_tap are 0 in both clock phases, even when d is 1.
- R8: When the controls return to normal mode during a low phase after a test mode, q keeps the test-mode constant until the next rising edge. At that edge q takes the d present at the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the master is transparent while low, the slave while high |
| rst_n | input | 1 | Asynchronous active-low clear of both latch stores |
| d | input | 1 | Data input |
| mst_c1 | input | 1 | Master mode control, selected when the stored bit is 0 |
| mst_c2 | input | 1 | Master mode control, selected when the stored bit is 1 |
| slv_c1 | input | 1 | Slave mode control, selected when the stored bit is 0 |
| slv_c2 | input | 1 | Slave mode control, selected when the stored bit is 1 |
| q | output | 1 | Flip-flop output |
| mst_tap | output | 1 | Master feedback tap |
| slv_tap | output | 1 | Slave feedback tap |

## Verification
A wrong value in the master store appears on mst_tap in the same low phase. It then reaches q directly after the next rising edge. A wrong value in the slave store appears on both slv_tap and q in the low phase in which it occurs, so a loss of hold is seen within half a clock period. In the test modes, a tap or output that does not reach its forced constant shows the broken loop at once, in either clock phase. The bench therefore samples the ports in both phases of every cycle and toggles d inside phases to catch any leak of data through a closed latch.

// File: rtl/swapgate_pkg.sv
package swapgate_pkg;

  // Control settings, ordered {mst_c1, mst_c2, slv_c1, slv_c2}
  typedef enum logic [3:0] {
    CTL_NORMAL = 4'b0101,
    CTL_ALL0   = 4'b0000,
    CTL_ALL1   = 4'b1111
  } ctl_mode_e;

  // Data inputs that turn a swap gate into a copy element (q = a)
  localparam logic DUP_B = 1'b0;
  localparam logic DUP_C = 1'b1;

  // Data inputs that turn a swap gate into an inverter (q = ~a, r = a)
  localparam logic INV_B = 1'b1;
  localparam logic INV_C = 1'b0;

  // Controlled swap: {p, q, r}
  function automatic logic [2:0] cswap(input logic a, input logic b, input logic c);
    return {a, (~a & b) | (a & c), (a & b) | (~a & c)};
  endfunction

endpackage

// File: rtl/swapgate_cell.sv
module swapgate_cell
  import swapgate_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);

  assign {p, q, r} = cswap(a, b, c);

endmodule

// File: rtl/swapgate_latch.sv
module swapgate_latch
  import swapgate_pkg::*;
(
  input  logic rst_n,
  input  logic en,
  input  logic d,
  input  logic c1,
  input  logic c2,
  output logic lq,
  output logic tap
);

  logic d_mux, d_store, unused_dsplit;
  logic held;
  logic tap_i, unused_fb_p, unused_fb_r;
  logic tap_mux, unused_tsplit;
  logic unused_mux_p, unused_mux_r;

  // Duplicate the data input for the output path and the store
  swapgate_cell u_dsplit (
    .a(d), .b(DUP_B), .c(DUP_C),
    .p(d_mux), .q(d_store), .r(unused_dsplit)
  );

  // Storage element: follows data while enabled
  always_latch begin
    if (!rst_n) begin
      held <= 1'b0;
    end else if (en) begin
      held <= d_store;
    end
  end

  // Feedback tap: repeats the stored bit for (c1,c2)=(0,1), else forced
  swapgate_cell u_fb (
    .a(held), .b(c1), .c(c2),
    .p(unused_fb_p), .q(tap_i), .r(unused_fb_r)
  );

  // Duplicate the tap for the port and the output selector
  swapgate_cell u_tsplit (
    .a(tap_i), .b(DUP_B), .c(DUP_C),
    .p(tap), .q(tap_mux), .r(unused_tsplit)
  );

  // Output selector: data when enabled, tap when closed
  swapgate_cell u_mux (
    .a(en), .b(tap_mux), .c(d_mux),
    .p(unused_mux_p), .q(lq), .r(unused_mux_r)
  );

endmodule

// File: rtl/swapgate_msdff.sv
module swapgate_msdff
  import swapgate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic mst_c1,
  input  logic mst_c2,
  input  logic slv_c1,
  input  logic slv_c2,
  output logic q,
  output logic mst_tap,
  output logic slv_tap
);

  logic unused_clk_p, clk_lo_en, clk_hi_en;
  logic m_out;

  // Complementary latch enables from one clock
  swapgate_cell u_clksplit (
    .a(clk), .b(INV_B), .c(INV_C),
    .p(unused_clk_p), .q(clk_lo_en), .r(clk_hi_en)
  );

  swapgate_latch u_master (
    .rst_n(rst_n),
    .en   (clk_lo_en),
    .d    (d),
    .c1   (mst_c1),
    .c2   (mst_c2),
    .lq   (m_out),
    .tap  (mst_tap)
  );

  swapgate_latch u_slave (
    .rst_n(rst_n),
    .en   (clk_hi_en),
    .d    (m_out),
    .c1   (slv_c1),
    .c2   (slv_c2),
    .lq   (q),
    .tap  (slv_tap)
  );

endmodule

// File: rtl/swapgate_msdff_chk.sv
module swapgate_msdff_chk
  import swapgate_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic d,
  input logic mst_c1,
  input logic mst_c2,
  input logic slv_c1,
  input logic slv_c2,
  input logic q,
  input logic mst_tap,
  input logic slv_tap
);

  logic [3:0] ctl;
  logic       md_norm, md_zero, md_one;

  assign ctl     = {mst_c1, mst_c2, slv_c1, slv_c2};
  assign md_norm = (ctl == CTL_NORMAL);
  assign md_zero = (ctl == CTL_ALL0);
  assign md_one  = (ctl == CTL_ALL1);

  // Sampled just before each rising edge, i.e. late in the low phase
  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (md_norm && $past(md_norm) && $past(rst_n)) |-> (q == $past(d))); // R1

  AST_MASTER_TAP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    md_norm |-> (mst_tap == d)); // R3

  AST_SLAVE_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    md_norm |-> (slv_tap == q)); // R3

  AST_ZERO_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
    md_zero |-> (!mst_tap && !slv_tap)); // R4

  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    md_zero |-> !q); // R5

  AST_ONE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    md_one |-> (mst_tap && slv_tap && q)); // R6

endmodule

bind swapgate_msdff swapgate_msdff_chk u_chk (.*);

// File: tb/swapgate_msdff_tb.sv
`timescale 1ns/100ps
module swapgate_msdff_tb;
  import swapgate_pkg::*;

  logic clk = 1'b0;
  logic rst_n, d, mst_c1, mst_c2, slv_c1, slv_c2;
  logic q, mst_tap, slv_tap;

  int total = 0;
  int bad   = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];
  string      ttag_q[$];
  logic       q_model;
  logic [3:0] prev_mode;

  always #2.5 clk = ~clk;

  swapgate_msdff u_dut (
    .clk(clk), .rst_n(rst_n), .d(d),
    .mst_c1(mst_c1), .mst_c2(mst_c2), .slv_c1(slv_c1), .slv_c2(slv_c2),
    .q(q), .mst_tap(mst_tap), .slv_tap(slv_tap)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: compares high-phase outputs against queued expectations
  logic [2:0] m_e;
  string      m_t, m_tt;
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      m_e  = exp_q.pop_front();
      m_t  = tag_q.pop_front();
      m_tt = ttag_q.pop_front();
      check(m_t,  "q high phase",       q,       m_e[2]);
      check(m_tt, "mst_tap high phase", mst_tap, m_e[1]);
      check(m_tt, "slv_tap high phase", slv_tap, m_e[0]);
    end
  end

  // Driver: applies one cycle of stimulus and queues its expected result
  task automatic step(input logic dv, input logic [3:0] mode, input bit wiggle);
    logic  eq;
    string qtag, ttag;
    @(negedge clk);
    d = dv;
    {mst_c1, mst_c2, slv_c1, slv_c2} = mode;
    #1;
    if (mode == CTL_NORMAL) begin
      check("R3", "mst_tap low phase", mst_tap, dv);
      check("R3", "slv_tap low phase", slv_tap, q_model);
      check((prev_mode != CTL_NORMAL) ? "R8" : "R2", "q low phase", q, q_model);
      eq   = dv;
      qtag = (prev_mode != CTL_NORMAL) ? "R8" : "R1";
      ttag = "R3";
    end else if (mode == CTL_ALL0) begin
      check("R4", "mst_tap low phase", mst_tap, 1'b0);
      check("R4", "slv_tap low phase", slv_tap, 1'b0);
      check("R5", "q low phase", q, 1'b0);
      eq = 1'b0; qtag = "R5"; ttag = "R4";
    end else begin
      check("R6", "mst_tap low phase", mst_tap, 1'b1);
      check("R6", "slv_tap low phase", slv_tap, 1'b1);
      check("R6", "q low phase", q, 1'b1);
      eq = 1'b1; qtag = "R6"; ttag = "R6";
    end
    exp_q.push_back({eq, eq, eq});
    tag_q.push_back(qtag);
    ttag_q.push_back(ttag);
    q_model   = eq;
    prev_mode = mode;
    if (wiggle) begin
      @(posedge clk);
      #1.5;
      d = ~dv;
      #0.6;
      check((mode == CTL_NORMAL) ? "R2" : qtag, "q after d toggle in high phase", q, eq);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    d     = 1'b1;
    {mst_c1, mst_c2, slv_c1, slv_c2} = CTL_NORMAL;
    q_model   = 1'b0;
    prev_mode = CTL_NORMAL;

    // R7: reset holds everything at 0 in both phases, with d = 1
    @(negedge clk); #1;
    check("R7", "q reset low phase", q, 1'b0);
    check("R7", "mst_tap reset low phase", mst_tap, 1'b0);
    check("R7", "slv_tap reset low phase", slv_tap, 1'b0);
    @(posedge clk); #1;
    check("R7", "q reset high phase", q, 1'b0);
    check("R7", "mst_tap reset high phase", mst_tap, 1'b0);
    check("R7", "slv_tap reset high phase", slv_tap, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    d     = 1'b0;

    // Normal storage, R1 R2 R3
    step(1'b1, CTL_NORMAL, 1'b1);
    step(1'b0, CTL_NORMAL, 1'b0);
    step(1'b0, CTL_NORMAL, 1'b1);
    step(1'b1, CTL_NORMAL, 1'b0);
    step(1'b1, CTL_NORMAL, 1'b1);
    step(1'b0, CTL_NORMAL, 1'b0);
    step(1'b1, CTL_NORMAL, 1'b0);

    // All-zeros test mode, R4 R5
    step(1'b0, CTL_ALL0, 1'b0);
    step(1'b1, CTL_ALL0, 1'b1);
    step(1'b0, CTL_ALL0, 1'b1);

    // Back to normal, R8
    step(1'b1, CTL_NORMAL, 1'b0);
    step(1'b0, CTL_NORMAL, 1'b1);

    // All-ones test mode, R6
    step(1'b1, CTL_ALL1, 1'b0);
    step(1'b0, CTL_ALL1, 1'b1);

    // Back to normal from ones, R8
    step(1'b0, CTL_NORMAL, 1'b0);
    step(1'b1, CTL_NORMAL, 1'b0);

    @(posedge clk); #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule